// File: doc/BRIEF.md
# DMA Interrupt Status and Enable Word

This block is the single 32-bit interrupt word that sits beside a seven-channel DMA engine. Each channel engine reports a one-cycle pulse when its transfer finishes and another when it hits a bus error. The word records those events in sticky per-channel flags and merges them into one level interrupt line for the CPU.

Software sets a global enable and a per-channel enable through the CPU port. It also writes six general bits and the bus-error bit, and clears flags by writing ones into their positions. A completion only leaves a flag behind when both its channel enable and the global enable were set. A bus error always leaves one, together with the shared bus-error bit. The top bit is never stored. It is computed from the stored bits and drives the interrupt pin.

Top module: `dma_irq_word`

## Requirements
- R1: While reset is held and after it is released, the word reads 0x0000_0000 and `irq` is low.
- R2: A write with `wr_en` high loads `wr_data` bits 0–5 and 15–23 into the same positions. Bits 6–14 always read 0. Written values of bits 24–31 never set anything.
- R3: A write with a 1 in bit 24+i (i = 0..6) clears flag i. A 0 there leaves the flag unchanged.
- R4: A `done_i[i]` pulse sets flag i (bit 24+i) only if channel enable bit 16+i and global enable bit 23 were both 1 in the cycle of the pulse.
- R5: A `berr_i[i]` pulse sets bit 15 and flag i, whatever the enables hold.
- R6: Bit 31 reads as bit 15 OR (bit 23 AND any of bits 24–30). Bit 31 is never stored.
- R7: `irq` always equals bit 31 of `rd_data`.
- R8: When a CPU write clears a flag or bit 15 in the same cycle as a channel event sets it, the bit ends up set.
- R9: Every write and event takes effect on the clock edge that samples it, and shows on `rd_data`/`irq` in the cycle after that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | CPU write strobe for the word |
| wr_data | input | 32 | CPU write data |
| done_i | input | 7 | Per-channel completion pulse |
| berr_i | input | 7 | Per-channel bus-error pulse |
| rd_data | output | 32 | Current contents of the word, including the computed bit 31 |
| irq | output | 1 | Level interrupt request |

## Verification
Writes, completions and bus errors are all sampled on one edge. Each result shows on `rd_data` and `irq` one cycle later, with no further latency, because bit 31 and the interrupt are computed from the stored bits. The bench drives inputs on the falling edge. It advances its behavioural model on the rising edge, and compares the whole word and the interrupt on the next falling edge. Every expected value is therefore taken exactly one edge after the stimulus that caused it. The same-cycle clear/set case and the enable gating rest on enable values from before the edge, and the model uses those same old values.

// File: rtl/dma_irq_pkg.sv
package dma_irq_pkg;
    localparam int NUM_CH     = 7;
    localparam int WORD_W     = 32;
    localparam int SCR_W      = 6;
    localparam int BERR_BIT   = 15;
    localparam int EN_LSB     = 16;
    localparam int GEN_BIT    = EN_LSB + NUM_CH;
    localparam int FLAG_LSB   = GEN_BIT + 1;
    localparam int MASTER_BIT = FLAG_LSB + NUM_CH;
    localparam int GAP_W      = BERR_BIT - SCR_W;

    typedef struct packed {
        logic [SCR_W-1:0]  scratch;
        logic              berr;
        logic [NUM_CH-1:0] en;
        logic              gen;
        logic [NUM_CH-1:0] flag;
    } irq_state_t;
endpackage

// File: rtl/irq_cpu_write.sv
module irq_cpu_write
    import dma_irq_pkg::*;
(
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_data,
    input  irq_state_t        cur_q,
    output irq_state_t        after_wr
);
    logic [NUM_CH-1:0] clr_mask;

    always_comb begin
        clr_mask = wr_en ? wr_data[FLAG_LSB +: NUM_CH] : '0;
        after_wr = cur_q;
        if (wr_en) begin
            after_wr.scratch = wr_data[SCR_W-1:0];
            after_wr.berr    = wr_data[BERR_BIT];
            after_wr.en      = wr_data[EN_LSB +: NUM_CH];
            after_wr.gen     = wr_data[GEN_BIT];
        end
        after_wr.flag = cur_q.flag & ~clr_mask;
    end
endmodule

// File: rtl/irq_event_merge.sv
module irq_event_merge
    import dma_irq_pkg::*;
#(
    parameter int CH = NUM_CH
) (
    input  logic [CH-1:0] done_i,
    input  logic [CH-1:0] berr_i,
    input  logic [CH-1:0] en_q,
    input  logic          gen_q,
    output logic [CH-1:0] flag_set,
    output logic          berr_set
);
    for (genvar i = 0; i < CH; i++) begin : g_ch
        assign flag_set[i] = berr_i[i] | (done_i[i] & en_q[i] & gen_q);
    end
    assign berr_set = |berr_i;
endmodule

// File: rtl/irq_readout.sv
module irq_readout
    import dma_irq_pkg::*;
(
    input  irq_state_t        st_q,
    output logic [WORD_W-1:0] word,
    output logic              master
);
    always_comb begin
        master = st_q.berr | (st_q.gen & (|st_q.flag));
        word   = {master, st_q.flag, st_q.gen, st_q.en, st_q.berr,
                  {GAP_W{1'b0}}, st_q.scratch};
    end
endmodule

// File: rtl/dma_irq_word.sv
module dma_irq_word
    import dma_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_data,
    input  logic [NUM_CH-1:0] done_i,
    input  logic [NUM_CH-1:0] berr_i,
    output logic [WORD_W-1:0] rd_data,
    output logic              irq
);
    irq_state_t        state_q, state_d, after_wr;
    logic [NUM_CH-1:0] flag_set;
    logic              berr_set;
    logic              master;

    irq_cpu_write u_wr (
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .cur_q   (state_q),
        .after_wr(after_wr)
    );

    irq_event_merge #(.CH(NUM_CH)) u_ev (
        .done_i  (done_i),
        .berr_i  (berr_i),
        .en_q    (state_q.en),
        .gen_q   (state_q.gen),
        .flag_set(flag_set),
        .berr_set(berr_set)
    );

    irq_readout u_rd (
        .st_q  (state_q),
        .word  (rd_data),
        .master(master)
    );

    // hardware sets are applied after the CPU write so they win (R8)
    always_comb begin
        state_d      = after_wr;
        state_d.flag = after_wr.flag | flag_set;
        state_d.berr = after_wr.berr | berr_set;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign irq = master;

    a_r2_write_loads: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (rd_data[GEN_BIT:EN_LSB] == $past(wr_data[GEN_BIT:EN_LSB]))
               && (rd_data[SCR_W-1:0] == $past(wr_data[SCR_W-1:0])));

    a_r2_gap_zero: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[BERR_BIT-1:SCR_W] == '0);

    a_r5_berr_bit: assert property (@(posedge clk) disable iff (!rst_n)
        (|berr_i) |=> rd_data[BERR_BIT]);

    a_r7_irq_level: assert property (@(posedge clk) disable iff (!rst_n)
        irq == rd_data[MASTER_BIT]);

    for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
        a_r4_done_sets: assert property (@(posedge clk) disable iff (!rst_n)
            (done_i[i] && rd_data[EN_LSB+i] && rd_data[GEN_BIT]) |=> rd_data[FLAG_LSB+i]);

        a_r4_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(rd_data[FLAG_LSB+i]) |->
                $past(berr_i[i] || (done_i[i] && rd_data[EN_LSB+i] && rd_data[GEN_BIT])));

        a_r5_berr_flag: assert property (@(posedge clk) disable iff (!rst_n)
            berr_i[i] |=> rd_data[FLAG_LSB+i]);

        a_r3_clear: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && wr_data[FLAG_LSB+i] && !berr_i[i]
                && !(done_i[i] && rd_data[EN_LSB+i] && rd_data[GEN_BIT]))
            |=> !rd_data[FLAG_LSB+i]);
    end
endmodule

// File: tb/tb_dma_irq_word.sv
`timescale 1ns/1ps
module tb_dma_irq_word;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [6:0]  done_i = '0;
    logic [6:0]  berr_i = '0;
    logic [31:0] rd_data;
    logic        irq;

    dma_irq_word dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .done_i(done_i), .berr_i(berr_i), .rd_data(rd_data), .irq(irq)
    );

    always #2.5 clk = ~clk;

    int unsigned model = 0;
    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    bit finished = 0;
    string tag = "R1";

    // behavioural reference: one update per rising edge
    always @(posedge clk) begin
        int unsigned nxt;
        bit anyflag;
        cycles++;
        if (!rst_n) begin
            model = 0;
        end else begin
            nxt = model & 32'h7FFF_FFFF;
            if (wr_en) begin
                nxt = (nxt & ~32'h00FF_803F) | (wr_data & 32'h00FF_803F);
                nxt = nxt & ~(wr_data & 32'h7F00_0000);
            end
            for (int c = 0; c < 7; c++) begin
                if (berr_i[c]) nxt = nxt | (32'h1 << 15) | (32'h1 << (24 + c));
                if (done_i[c] && model[16+c] && model[23]) nxt = nxt | (32'h1 << (24 + c));
            end
            anyflag = (nxt & 32'h7F00_0000) != 0;
            if (nxt[15] || (nxt[23] && anyflag)) nxt = nxt | 32'h8000_0000;
            model = nxt;
        end
    end

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (!finished) begin
            check(tag, rd_data, model);
            check("R7", {31'b0, irq}, {31'b0, rd_data[31]});
            check("R6", {31'b0, rd_data[31]},
                  {31'b0, rd_data[15] | (rd_data[23] & (|rd_data[30:24]))});
        end
    end

    task automatic step(bit w, logic [31:0] d, logic [6:0] dn, logic [6:0] be);
        @(negedge clk);
        wr_en = w; wr_data = d; done_i = dn; berr_i = be;
        @(negedge clk);
        wr_en = 0; wr_data = '0; done_i = '0; berr_i = '0;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin
        wait (cycles > 200000);
        fails++;
        $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
        finish_run();
    end

    initial begin
        tag = "R1";
        repeat (4) @(negedge clk);
        rst_n = 1;
        repeat (2) @(negedge clk);
        check("R1", rd_data, 32'h0);
        tag = "R2";
        step(1, 32'hFFFF_FFFF, 0, 0);
        check("R2", rd_data, 32'h80FF_803F);
        step(1, 32'h0055_0015, 0, 0);
        check("R2", rd_data, 32'h0055_0015);
        tag = "R4";
        step(1, 32'h0084_0000, 0, 0);
        step(0, 0, 7'h7F, 0);
        check("R4", rd_data, 32'h8484_0000);
        step(1, 32'h0004_0000, 0, 0);
        step(0, 0, 7'h7B, 0);
        check("R4", rd_data, 32'h0404_0000);
        tag = "R3";
        step(1, 32'h0184_0000, 0, 0);
        check("R3", rd_data, 32'h8484_0000);
        step(1, 32'h0484_0000, 0, 0);
        check("R3", rd_data, 32'h0084_0000);
        tag = "R5";
        step(1, 32'h0000_0000, 0, 0);
        step(0, 0, 0, 7'h20);
        check("R5", rd_data, 32'hA000_8000);
        tag = "R8";
        step(1, 32'h2081_0000, 0, 7'h20);
        check("R8", rd_data, 32'hA081_8000);
        step(1, 32'h6181_0000, 7'h01, 0);
        check("R8", rd_data, 32'h8181_0000);
        tag = "R9";
        for (int k = 0; k < 400; k++) begin
            @(negedge clk);
            wr_en   = ($urandom % 4) == 0;
            wr_data = $urandom;
            done_i  = 7'($urandom) & 7'($urandom);
            berr_i  = (($urandom % 8) == 0) ? 7'(1 << ($urandom % 7)) : 7'h0;
        end
        @(negedge clk);
        wr_en = 0; done_i = '0; berr_i = '0;
        repeat (2) @(negedge clk);
        tag = "R1";
        rst_n = 0;
        repeat (2) @(negedge clk);
        check("R1", {31'b0, irq}, 32'h0);
        finish_run();
    end
endmodule